// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshake Pointer Crossing

This block carries data words from a producer clock domain to a consumer clock domain. Words are pushed on the write clock and popped on the read clock. The two clocks may run at unrelated rates. Storage is a simple dual-port array whose depth is a power of two. Both position counters are plain binary values, one bit wider than the address.

Neither counter is Gray-coded. Each one reaches the opposite domain through a toggle handshake. The sending side captures the counter into a holding register and flips a request bit. The receiving side sees the request through a two-flop synchronizer, copies the held value and flips an acknowledge bit, which travels back through its own synchronizer. The sender takes the next sample only once that acknowledge has returned, so each domain works against a slightly stale copy of the remote counter. As a result, "full" may be reported too early and "empty" may be reported too late, but never the other way round.

A push while full is dropped. A pop while empty is reported as a one-cycle error pulse, leaves the output word untouched and does not move the read counter. Each domain has its own synchronous active-high reset.

Top module: `hs_async_fifo`

## Requirements
- R1: When both resets have been released, `empty` is 1 and `full`, `rd_valid` and `rd_err` are all 0.
- R2: Every accepted word comes out on `rd_data` exactly once, unchanged and in the order it was pushed. A push is accepted when `wr_en` is high and `full` is low at a write-clock edge.
- R3: After DEPTH accepted pushes with no pops, `full` is 1 and further pushes are dropped. The write counter never gets more than DEPTH entries ahead of its copy of the read counter.
- R4: A pop while `empty` is 1 raises `rd_err` for exactly one read cycle. In that cycle `rd_valid` stays 0 and `rd_data` holds its previous value. The read counter does not advance, so the next accepted pop returns the oldest unread word.
- R5: The read counter never moves past its copy of the write counter.
- R6: In the sending domain, the held counter sample does not change while a request is outstanding, meaning the request bit differs from the synchronized acknowledge.
- R7: In the receiving domain, the counter copy changes only in a cycle where the acknowledge bit toggles.
- R8: The flags are conservative. `empty` does not clear within the first read-clock cycle after a push, but it clears within 20 read cycles. `full` clears within 20 write cycles once the FIFO has been drained.
- R9: `rd_valid` is high for exactly one read cycle after each accepted pop, and `rd_data` is valid in that cycle. With no pop, `rd_valid` and `rd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | W | Word to push |
| full | output | 1 | No room for a push (conservative) |
| rclk | input | 1 | Read-domain clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Pop request |
| rd_data | output | W | Popped word, held between pops |
| rd_valid | output | 1 | `rd_data` carries a newly popped word |
| rd_err | output | 1 | The previous pop found the FIFO empty |
| empty | output | 1 | No word available (conservative) |

## Verification
Pushes and pops can land in the same stretch of time while a counter transfer is still in flight. A pop on an empty FIFO can also coincide with a push that has not yet crossed. The bench provokes both with concurrent random enable streams on the two clocks, at write-heavy, read-heavy and balanced mixes, so that `full` and `empty` are both reached during concurrent traffic. A reference queue fed only with accepted pushes judges every pop outcome. It expects a word and `rd_valid` when `empty` was low at the pop, and an error pulse with an unchanged `rd_data` when it was high.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // outcome of a pop request in the read domain
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WORD  = 2'd1,
    RD_FAULT = 2'd2
  } rd_kind_t;
endpackage

// File: rtl/afifo_bit_sync.sv
module afifo_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output register keeps its word until the next accepted pop
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/afifo_ptr_xfer.sv
module afifo_ptr_xfer #(
  parameter int PW     = 6,
  parameter int STAGES = 2
) (
  input  logic          s_clk,
  input  logic          s_rst,
  input  logic [PW-1:0] s_ptr,
  input  logic          d_clk,
  input  logic          d_rst,
  output logic [PW-1:0] d_ptr
);
  logic [PW-1:0] hold;
  logic          req, req_d;
  logic          ack, ack_s;

  // sender: resample only after the previous transfer was acknowledged
  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      hold <= '0;
      req  <= 1'b0;
    end else if (ack_s == req) begin
      hold <= s_ptr;
      req  <= ~req;
    end
  end

  afifo_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(d_clk), .rst(d_rst), .d(req), .q(req_d)
  );

  // receiver: copy the held sample once the request is seen
  always_ff @(posedge d_clk) begin
    if (d_rst) begin
      d_ptr <= '0;
      ack   <= 1'b0;
    end else if (req_d != ack) begin
      d_ptr <= hold;
      ack   <= ~ack;
    end
  end

  afifo_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(s_clk), .rst(s_rst), .d(ack), .q(ack_s)
  );

  p_hold_stable_r6: assert property (@(posedge s_clk) disable iff (s_rst)
    (req != ack_s) |=> $stable(hold));

  p_copy_on_ack_r7: assert property (@(posedge d_clk) disable iff (d_rst)
    !$stable(d_ptr) |-> !$stable(ack));
endmodule

// File: rtl/hs_async_fifo.sv
module hs_async_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         rd_err,
  output logic         empty
);
  import afifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] wptr, rptr_w, rptr, wptr_r;
  logic [PW-1:0] wr_level, rd_level;
  logic          we, re;
  rd_kind_t      rd_kind;

  // write domain
  assign wr_level = wptr - rptr_w;
  assign full     = wr_level[AW];
  assign we       = wr_en && !full;

  always_ff @(posedge wclk) begin
    if (wrst)    wptr <= '0;
    else if (we) wptr <= wptr + PW'(1);
  end

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (wrst)
    (wptr - rptr_w) <= CAP);

  // read domain
  assign rd_level = wptr_r - rptr;
  assign empty    = (rd_level == '0);
  assign re       = rd_en && !empty;

  always_comb begin
    if (re)         rd_kind = RD_WORD;
    else if (rd_en) rd_kind = RD_FAULT;
    else            rd_kind = RD_IDLE;
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr     <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      if (re) rptr <= rptr + PW'(1);
      rd_valid <= (rd_kind == RD_WORD);
      rd_err   <= (rd_kind == RD_FAULT);
    end
  end

  p_no_underflow_r5: assert property (@(posedge rclk) disable iff (rrst)
    (wptr_r - rptr) <= CAP);

  p_err_holds_data_r4: assert property (@(posedge rclk) disable iff (rrst)
    rd_err |-> ($stable(rd_data) && !rd_valid));

  p_err_no_advance_r4: assert property (@(posedge rclk) disable iff (rrst)
    rd_err |-> $stable(rptr));

  afifo_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .rrst(rrst), .re(re), .raddr(rptr[AW-1:0]),
    .rdata(rd_data)
  );

  afifo_ptr_xfer #(.PW(PW)) u_w2r (
    .s_clk(wclk), .s_rst(wrst), .s_ptr(wptr),
    .d_clk(rclk), .d_rst(rrst), .d_ptr(wptr_r)
  );

  afifo_ptr_xfer #(.PW(PW)) u_r2w (
    .s_clk(rclk), .s_rst(rrst), .s_ptr(rptr),
    .d_clk(wclk), .d_rst(wrst), .d_ptr(rptr_w)
  );
endmodule

// File: tb/hs_async_fifo_bench.sv
`timescale 1ns/1ps
module hs_async_fifo_bench;
  localparam int W     = 16;
  localparam int DEPTH = 32;

  logic         wclk = 1'b0, rclk = 1'b0;
  logic         wrst = 1'b1, rrst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         full, empty, rd_valid, rd_err;

  always #2.5 wclk = ~wclk;   // 200 MHz write clock
  always #3.5 rclk = ~rclk;   // unrelated read clock

  hs_async_fifo #(.W(W), .DEPTH(DEPTH)) u_hs_async_fifo (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err), .empty(empty)
  );

  int total = 0;
  int bad   = 0;
  logic [W-1:0] model_q[$];
  int wr_seq   = 0;
  int accepted = 0;
  int pend     = 0;          // 0 none, 1 word expected, 2 error expected
  logic [W-1:0] exp_word = '0;
  logic [W-1:0] last_word = '0;

  function automatic logic [W-1:0] gen_word(input int n);
    return W'(n * 40503 + 7) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_cycle(input bit en);
    @(negedge wclk);
    wr_en   = en;
    wr_data = gen_word(wr_seq);
    wr_seq++;
    if (en && !full) begin
      model_q.push_back(wr_data);
      accepted++;
    end
  endtask

  // mode: 0 idle, 1 pop, 2 pop only when not empty
  task automatic rd_cycle(input int mode);
    @(negedge rclk);
    if (pend == 1) begin
      chk(rd_valid === 1'b1 && rd_err === 1'b0, "R9", "rd_valid after pop", rd_valid, 1);
      chk(rd_data === exp_word, "R2", "popped word", rd_data, exp_word);
      last_word = rd_data;
    end else if (pend == 2) begin
      chk(rd_err === 1'b1 && rd_valid === 1'b0, "R4", "error pulse", {rd_err, rd_valid}, 2'b10);
      chk(rd_data === last_word, "R4", "data held on error", rd_data, last_word);
    end else begin
      chk(rd_valid === 1'b0 && rd_err === 1'b0, "R9", "quiet without pop", {rd_err, rd_valid}, 0);
    end
    rd_en = (mode == 1) || (mode == 2 && !empty);
    if (rd_en) begin
      if (!empty) begin
        pend = 1;
        exp_word = model_q.pop_front();
      end else begin
        pend = 2;
      end
    end else begin
      pend = 0;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && model_q.size() > 0; i++) rd_cycle(2);
    rd_cycle(0);
    rd_cycle(0);
    chk(model_q.size() == 0, "R2", "all words drained", model_q.size(), 0);
  endtask

  task automatic mix(input int n, input int wpct, input int rpct);
    fork
      begin
        for (int i = 0; i < n; i++) wr_cycle($urandom_range(0, 99) < wpct);
        wr_cycle(0);
      end
      begin
        for (int i = 0; i < n; i++) rd_cycle(($urandom_range(0, 99) < rpct) ? 1 : 0);
        rd_cycle(0);
      end
    join
  endtask

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
    @(negedge rclk);
    // R1 reset state
    chk(empty === 1'b1, "R1", "empty after reset", empty, 1);
    chk(full === 1'b0, "R1", "full after reset", full, 0);
    chk(rd_valid === 1'b0 && rd_err === 1'b0, "R1", "read flags after reset", {rd_err, rd_valid}, 0);

    // R4 pop on an empty FIFO
    rd_cycle(1);
    rd_cycle(0);

    // R8 single word: empty is late, never early
    wr_cycle(1);
    wr_cycle(0);
    @(negedge rclk);
    chk(empty === 1'b1, "R8", "empty still set right after push", empty, 1);
    repeat (20) @(negedge rclk);
    chk(empty === 1'b0, "R8", "empty cleared after crossing", empty, 0);
    drain();

    // R3 fill beyond capacity with no pops
    accepted = 0;
    for (int i = 0; i < DEPTH + 4; i++) wr_cycle(1);
    wr_cycle(0);
    chk(accepted == DEPTH, "R3", "accepted pushes", accepted, DEPTH);
    chk(full === 1'b1, "R3", "full at capacity", full, 1);
    drain();
    rd_cycle(1);                       // R4 error after drain, then ordered data
    rd_cycle(0);
    repeat (20) @(negedge wclk);
    chk(full === 1'b0, "R8", "full cleared after drain", full, 0);

    // R4 error followed by a good pop returns the oldest word
    wr_cycle(1);
    wr_cycle(1);
    wr_cycle(0);
    rd_cycle(1);
    rd_cycle(0);
    drain();

    // concurrent random traffic (R2, R4, R9)
    mix(1500, 60, 55);
    drain();
    mix(800, 90, 20);
    drain();
    mix(800, 20, 90);
    drain();
    repeat (20) @(negedge wclk);
    chk(full === 1'b0 && empty === 1'b1, "R8", "idle flags at end", {full, empty}, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule